// File: doc/BRIEF.md
# Debug Mailbox Control Register

This block is the CPU-visible side of a debug mailbox shared by on-chip ROM debug routines and an external JTAG host. It holds a small flag register and a data holding buffer. The flag register carries a two-bit programming-source selector, a system-program-enable flag and a transfer-complete flag, and applies hardware set and clear rules to them. The holding buffer is the parallel load/unload point of the TAP debug shift register. The TAP controller and the shift register sit outside the block and appear only as strobes and data buses.

The CPU reaches both registers through one write port and one read port. A select input picks the register, and a per-bit write mask picks the bits that a write changes. The enable flag the CPU reads is the OR of its own writable bit and a program-enable bit held on the TAP side. A two-bit boot-mode output tells the reset flow whether to run the in-system programmer, and if so from which source, or to start user code.

Top module: `dbg_mailbox_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) every stored bit is 0. `cpu_rdata` reads 0 for both selects, `tap_cap_data` is 0 and `boot_mode` is 2'b00.
- R2: Flag register bits 7:4 always read 0, and writes to them have no effect on any state.
- R3: Flag register layout: bit 0 is transfer-complete, bit 1 is enable, bits 3:2 are the source select. `cpu_sel`=0 addresses the flag register and `cpu_sel`=1 the buffer. `cpu_rdata` shows the selected register combinationally. A write changes only the bits set in `cpu_wr_mask`, and the change is visible after the next rising edge.
- R4: Enable bit 1 reads as the OR of the CPU-writable enable bit and `tap_spe`.
- R5: The CPU-writable enable bit is cleared by `rod_evt` or `tlr` in the cycle after they are seen, even if a CPU write sets it in the same cycle. `tlr` clears nothing else in the block.
- R6: A flag write whose mask includes bit 0 or bit 1 leaves the source select at 00, even if the same write also addresses bits 3:2.
- R7: Transfer-complete is set by `tap_xfer_done` and cleared by `eng_txc_clr`. The set beats both a CPU write and the clear. A CPU write beats the clear.
- R8: `boot_mode` is 2'b00 (user code) while the read enable is 0. While it is 1, the source select maps as follows: 00 gives 2'b01 (program over JTAG), 01 gives 2'b10 (I2C bootloader), and 1x gives 2'b11 (exit loader).
- R9: The holding buffer is read/write under the mask, is cleared only by power-on reset, is unaffected by flag writes, and is always visible on `tap_cap_data`.
- R10: `tap_load` copies `tap_load_data` into the buffer and beats a CPU buffer write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tlr | input | 1 | Test-Logic-Reset pulse from the TAP, synchronous |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_sel | input | 1 | 0 = flag register, 1 = holding buffer |
| cpu_wr_mask | input | 8 | Per-bit write enable |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register value |
| tap_spe | input | 1 | TAP-side program-enable bit |
| tap_xfer_done | input | 1 | End of a TAP transfer, sets transfer-complete |
| eng_txc_clr | input | 1 | Debug-engine clear of transfer-complete |
| rod_evt | input | 1 | Event that clears the CPU enable bit |
| tap_load | input | 1 | Shift register unload into the buffer |
| tap_load_data | input | 8 | Data for `tap_load` |
| tap_cap_data | output | 8 | Buffer value for the shift register capture |
| boot_mode | output | 2 | Reset-flow decision code |

## Verification
The hardest states to reach are the same-cycle collisions: a CPU enable write against `rod_evt`, the transfer-done set against both the engine clear and a CPU write, and a TAP load against a CPU buffer write. The directed tasks drive each pair in one stimulus cycle and read the outcome on the next. A second hard case is a CPU enable bit at 0 hidden behind a TAP enable of 1. The bench reaches it by pulsing `rod_evt` while `tap_spe` is held high, then drops `tap_spe` and confirms that the enable and `boot_mode` fall together.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
    localparam int FLAG_BITS = 4;
    localparam int TXC_BIT   = 0;
    localparam int SPE_BIT   = 1;
    localparam int PSS_LO    = 2;
    localparam int PSS_W     = 2;

    typedef enum logic [1:0] {
        BOOT_USER     = 2'b00,
        BOOT_ISP_JTAG = 2'b01,
        BOOT_ISP_I2C  = 2'b10,
        BOOT_EXIT     = 2'b11
    } boot_mode_e;

    typedef struct packed {
        logic [PSS_W-1:0] pss;
        logic             spe;
        logic             txc;
    } flag_state_t;
endpackage

// File: rtl/dbg_flag_core.sv
module dbg_flag_core
    import dbg_mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 tlr,
    input  logic                 flag_wr,
    input  logic [FLAG_BITS-1:0] wr_mask,
    input  logic [FLAG_BITS-1:0] wr_data,
    input  logic                 xfer_done,
    input  logic                 txc_clr,
    input  logic                 rod_evt,
    output logic                 txc_q,
    output logic                 spe_q,
    output logic [PSS_W-1:0]     pss_q
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lowest priority: engine clear of transfer-complete
        if (txc_clr) st_d.txc = 1'b0;
        if (flag_wr) begin
            for (int i = 0; i < PSS_W; i++) begin
                if (wr_mask[PSS_LO+i]) st_d.pss[i] = wr_data[PSS_LO+i];
            end
            if (wr_mask[SPE_BIT]) st_d.spe = wr_data[SPE_BIT];
            if (wr_mask[TXC_BIT]) st_d.txc = wr_data[TXC_BIT];
            // touching either flag wipes the source select
            if (wr_mask[SPE_BIT] || wr_mask[TXC_BIT]) st_d.pss = '0;
        end
        // hardware set beats CPU write and engine clear
        if (xfer_done) st_d.txc = 1'b1;
        // enable clears beat a CPU set
        if (rod_evt || tlr) st_d.spe = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign txc_q = st_q.txc;
    assign spe_q = st_q.spe;
    assign pss_q = st_q.pss;
endmodule

// File: rtl/dbg_hold_buf.sv
module dbg_hold_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_mask,
    input  logic [W-1:0] cpu_data,
    input  logic         tap_load,
    input  logic [W-1:0] tap_data,
    output logic [W-1:0] buf_q
);
    logic [W-1:0] buf_d;

    always_comb begin
        buf_d = buf_q;
        if (cpu_wr)   buf_d = (buf_q & ~cpu_mask) | (cpu_data & cpu_mask);
        if (tap_load) buf_d = tap_data;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end
endmodule

// File: rtl/dbg_boot_decode.sv
module dbg_boot_decode
    import dbg_mbox_pkg::*;
(
    input  logic             spe_eff,
    input  logic [PSS_W-1:0] pss,
    output boot_mode_e       mode
);
    always_comb begin
        if (!spe_eff)         mode = BOOT_USER;
        else if (pss[PSS_W-1]) mode = BOOT_EXIT;
        else if (pss[0])       mode = BOOT_ISP_I2C;
        else                   mode = BOOT_ISP_JTAG;
    end
endmodule

// File: rtl/dbg_mailbox_ctrl.sv
module dbg_mailbox_ctrl
    import dbg_mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tlr,
    input  logic              cpu_wr_en,
    input  logic              cpu_sel,
    input  logic [DATA_W-1:0] cpu_wr_mask,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tap_spe,
    input  logic              tap_xfer_done,
    input  logic              eng_txc_clr,
    input  logic              rod_evt,
    input  logic              tap_load,
    input  logic [DATA_W-1:0] tap_load_data,
    output logic [DATA_W-1:0] tap_cap_data,
    output logic [1:0]        boot_mode
);
    logic             flag_wr, buf_wr, spe_eff;
    logic             txc_q, spe_cpu_q;
    logic [PSS_W-1:0] pss_q;
    logic [DATA_W-1:0] flag_rd, buf_q;
    boot_mode_e       mode;

    assign flag_wr = cpu_wr_en && !cpu_sel;
    assign buf_wr  = cpu_wr_en && cpu_sel;

    dbg_flag_core u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .tlr       (tlr),
        .flag_wr   (flag_wr),
        .wr_mask   (cpu_wr_mask[FLAG_BITS-1:0]),
        .wr_data   (cpu_wdata[FLAG_BITS-1:0]),
        .xfer_done (tap_xfer_done),
        .txc_clr   (eng_txc_clr),
        .rod_evt   (rod_evt),
        .txc_q     (txc_q),
        .spe_q     (spe_cpu_q),
        .pss_q     (pss_q)
    );

    dbg_hold_buf #(.W(DATA_W)) u_buf (
        .clk      (clk),
        .por_n    (por_n),
        .cpu_wr   (buf_wr),
        .cpu_mask (cpu_wr_mask),
        .cpu_data (cpu_wdata),
        .tap_load (tap_load),
        .tap_data (tap_load_data),
        .buf_q    (buf_q)
    );

    assign spe_eff = spe_cpu_q | tap_spe;

    dbg_boot_decode u_dec (
        .spe_eff (spe_eff),
        .pss     (pss_q),
        .mode    (mode)
    );

    always_comb begin
        flag_rd                   = '0;
        flag_rd[TXC_BIT]          = txc_q;
        flag_rd[SPE_BIT]          = spe_eff;
        flag_rd[PSS_LO +: PSS_W]  = pss_q;
    end

    assign cpu_rdata    = cpu_sel ? buf_q : flag_rd;
    assign tap_cap_data = buf_q;
    assign boot_mode    = mode;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              tlr,
    input logic              cpu_wr_en,
    input logic              cpu_sel,
    input logic [1:0]        mask_flags,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              tap_spe,
    input logic              tap_xfer_done,
    input logic              rod_evt,
    input logic              tap_load,
    input logic [DATA_W-1:0] tap_load_data,
    input logic [DATA_W-1:0] tap_cap_data,
    input logic [1:0]        boot_mode,
    input logic              txc_q,
    input logic              spe_cpu_q,
    input logic [1:0]        pss_q
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        !cpu_sel |-> cpu_rdata[DATA_W-1:4] == '0);

    p_tap_enable_r4: assert property (@(posedge clk) disable iff (!por_n)
        tap_spe |-> boot_mode != 2'b00);

    p_spe_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
        (rod_evt || tlr) |=> !spe_cpu_q);

    p_pss_wipe_r6: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_wr_en && !cpu_sel && (mask_flags != 2'b00)) |=> pss_q == 2'b00);

    p_txc_set_r7: assert property (@(posedge clk) disable iff (!por_n)
        tap_xfer_done |=> txc_q);

    p_user_boot_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!tap_spe && !spe_cpu_q) |-> boot_mode == 2'b00);

    p_tap_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
        tap_load |=> tap_cap_data == $past(tap_load_data));
endmodule

bind dbg_mailbox_ctrl dbg_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .tlr           (tlr),
    .cpu_wr_en     (cpu_wr_en),
    .cpu_sel       (cpu_sel),
    .mask_flags    (cpu_wr_mask[1:0]),
    .cpu_rdata     (cpu_rdata),
    .tap_spe       (tap_spe),
    .tap_xfer_done (tap_xfer_done),
    .rod_evt       (rod_evt),
    .tap_load      (tap_load),
    .tap_load_data (tap_load_data),
    .tap_cap_data  (tap_cap_data),
    .boot_mode     (boot_mode),
    .txc_q         (txc_q),
    .spe_cpu_q     (spe_cpu_q),
    .pss_q         (pss_q)
);

// File: tb/tb_dbg_mailbox_ctrl.sv
module tb_dbg_mailbox_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       tlr = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic       cpu_sel = 1'b0;
    logic [7:0] cpu_wr_mask = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tap_spe = 1'b0;
    logic       tap_xfer_done = 1'b0;
    logic       eng_txc_clr = 1'b0;
    logic       rod_evt = 1'b0;
    logic       tap_load = 1'b0;
    logic [7:0] tap_load_data = '0;
    logic [7:0] tap_cap_data;
    logic [1:0] boot_mode;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_mailbox_ctrl dut (
        .clk(clk), .por_n(por_n), .tlr(tlr),
        .cpu_wr_en(cpu_wr_en), .cpu_sel(cpu_sel),
        .cpu_wr_mask(cpu_wr_mask), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tap_spe(tap_spe), .tap_xfer_done(tap_xfer_done), .eng_txc_clr(eng_txc_clr),
        .rod_evt(rod_evt), .tap_load(tap_load), .tap_load_data(tap_load_data),
        .tap_cap_data(tap_cap_data), .boot_mode(boot_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one stimulus cycle: inputs set after a falling edge, released at the next
    task automatic step(input logic wr, input logic sel, input logic [7:0] mask,
                        input logic [7:0] data, input logic xfer, input logic clr,
                        input logic rod, input logic tl, input logic ld,
                        input logic [7:0] ld_data);
        cpu_wr_en = wr; cpu_sel = sel; cpu_wr_mask = mask; cpu_wdata = data;
        tap_xfer_done = xfer; eng_txc_clr = clr; rod_evt = rod; tlr = tl;
        tap_load = ld; tap_load_data = ld_data;
        @(negedge clk);
        cpu_wr_en = 0; cpu_wr_mask = '0; cpu_wdata = '0; tap_xfer_done = 0;
        eng_txc_clr = 0; rod_evt = 0; tlr = 0; tap_load = 0; tap_load_data = '0;
    endtask

    task automatic fwr(input logic [7:0] mask, input logic [7:0] data);
        step(1, 0, mask, data, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic chk_flag(input string req, input logic [7:0] exp);
        cpu_sel = 0; #1;
        chk(req, cpu_rdata, exp);
    endtask

    task automatic chk_buf(input string req, input logic [7:0] exp);
        cpu_sel = 1; #1;
        chk(req, cpu_rdata, exp);
        chk(req, tap_cap_data, exp);
        cpu_sel = 0;
    endtask

    task automatic chk_boot(input string req, input logic [1:0] exp);
        chk(req, {6'b0, boot_mode}, {6'b0, exp});
    endtask

    task automatic do_por();
        tap_spe = 0;
        @(negedge clk); por_n = 0;
        @(negedge clk); @(negedge clk); por_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_por();
        chk_flag("R1 flag reset", 8'h00);
        chk_buf("R1 buffer reset", 8'h00);
        chk_boot("R1 boot reset", 2'b00);
    endtask

    task automatic t_reserved();
        do_por();
        fwr(8'hF0, 8'hFF);
        chk_flag("R2 reserved write ignored", 8'h00);
        fwr(8'h0C, 8'h08);
        chk_flag("R3 select write", 8'h08);
        chk_boot("R8 select without enable", 2'b00);
        fwr(8'hFF, 8'hFF);
        chk_flag("R6 full write wipes select, R2 upper zero", 8'h03);
    endtask

    task automatic t_decode();
        do_por();
        fwr(8'h02, 8'h02);
        chk_flag("R3 enable write", 8'h02);
        chk_boot("R8 jtag", 2'b01);
        fwr(8'h0C, 8'h04);
        chk_flag("R3 select 01", 8'h06);
        chk_boot("R8 i2c", 2'b10);
        fwr(8'h0C, 8'h0C);
        chk_boot("R8 exit 11", 2'b11);
        fwr(8'h0C, 8'h08);
        chk_flag("R3 select 10", 8'h0A);
        chk_boot("R8 exit 10", 2'b11);
        fwr(8'h0C, 8'h00);
        chk_boot("R8 back to jtag", 2'b01);
    endtask

    task automatic t_wipe();
        do_por();
        fwr(8'h0C, 8'h04);
        chk_flag("R6 setup", 8'h04);
        fwr(8'h01, 8'h00);
        chk_flag("R6 txc write wipes", 8'h00);
        fwr(8'h0C, 8'h0C);
        fwr(8'h02, 8'h00);
        chk_flag("R6 enable write 0 wipes", 8'h00);
        fwr(8'h0E, 8'h06);
        chk_flag("R6 wipe beats same write", 8'h02);
    endtask

    task automatic t_spe_clear();
        do_por();
        fwr(8'h02, 8'h02);
        step(0, 0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00);
        chk_flag("R5 rod clears", 8'h00);
        chk_boot("R5 rod boot user", 2'b00);
        step(1, 0, 8'h02, 8'h02, 0, 0, 1, 0, 0, 8'h00);
        chk_flag("R5 rod beats write", 8'h00);
        fwr(8'h02, 8'h02);
        fwr(8'h0C, 8'h04);
        step(0, 0, 8'h00, 8'h00, 1, 0, 0, 0, 0, 8'h00);
        chk_flag("R5 setup", 8'h07);
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00);
        chk_flag("R5 tlr clears enable only", 8'h05);
    endtask

    task automatic t_or();
        do_por();
        tap_spe = 1; #1;
        chk_flag("R4 tap enable reads", 8'h02);
        chk_boot("R4 tap enable boot", 2'b01);
        fwr(8'h0C, 8'h04);
        chk_boot("R4 tap enable i2c", 2'b10);
        step(0, 0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00);
        chk_flag("R4 OR hides cleared cpu bit", 8'h06);
        tap_spe = 0; #1;
        chk_flag("R4 tap drop", 8'h04);
        chk_boot("R4 tap drop boot", 2'b00);
    endtask

    task automatic t_txc();
        do_por();
        step(0, 0, 8'h00, 8'h00, 1, 0, 0, 0, 0, 8'h00);
        chk_flag("R7 set", 8'h01);
        step(0, 0, 8'h00, 8'h00, 0, 1, 0, 0, 0, 8'h00);
        chk_flag("R7 engine clear", 8'h00);
        step(0, 0, 8'h00, 8'h00, 1, 1, 0, 0, 0, 8'h00);
        chk_flag("R7 set beats clear", 8'h01);
        step(1, 0, 8'h01, 8'h00, 1, 0, 0, 0, 0, 8'h00);
        chk_flag("R7 set beats cpu write", 8'h01);
        fwr(8'h01, 8'h00);
        chk_flag("R7 cpu write clears", 8'h00);
        step(1, 0, 8'h01, 8'h01, 0, 1, 0, 0, 0, 8'h00);
        chk_flag("R7 cpu write beats clear", 8'h01);
    endtask

    task automatic t_buf();
        do_por();
        step(1, 1, 8'hFF, 8'hA5, 0, 0, 0, 0, 0, 8'h00);
        chk_buf("R9 full write", 8'hA5);
        step(1, 1, 8'h0F, 8'h3C, 0, 0, 0, 0, 0, 8'h00);
        chk_buf("R9 masked write", 8'hAC);
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00);
        chk_buf("R9 tlr keeps buffer", 8'hAC);
        fwr(8'hFF, 8'hFF);
        chk_buf("R9 flag write keeps buffer", 8'hAC);
    endtask

    task automatic t_tap();
        do_por();
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h5A);
        chk_buf("R10 tap load", 8'h5A);
        step(1, 1, 8'hFF, 8'hFF, 0, 0, 0, 0, 1, 8'h11);
        chk_buf("R10 tap beats cpu", 8'h11);
        step(1, 1, 8'hF0, 8'h00, 0, 0, 0, 0, 0, 8'h00);
        chk_buf("R10 cpu after load", 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_reserved();
        t_decode();
        t_wipe();
        t_spe_clear();
        t_or();
        t_txc();
        t_buf();
        t_tap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule